// File: doc/BRIEF.md
# Monitor Receive Command Injector

This block sits on the peripheral side of a byte-wide flow-controlled link to a controller. A local user writes an ASCII command, one byte per cycle, into an internal buffer and then launches it. The block offers the bytes to the controller one at a time: the current byte is valid while the empty flag is low, and each read strobe from the controller moves it to the next byte. The empty flag goes high only as a result of a controller read, never on its own, because the controller may sample it several cycles before it reads.

When the controller comes out of reset it reads twice more than it needs to. To absorb those reads, the block holds two space bytes (0x20) in front of anything the user loads after reset. Once the controller has accepted a command it sends the command back on its transmit channel. The block compares this echo with what it sent and reports either done or mismatch. It never asserts the transmit full flag, because every echoed byte is consumed in the cycle it arrives.

Top module: `cmdInjector`

## Requirements
- R1: After reset, rxEmpty is low, rxData shows 0x20, cmdReady is high, and done and mismatch are low.
- R2: After reset, the first two accepted reads return filler bytes 0x20, ahead of any loaded command. If no command has been launched, rxEmpty is high in the cycle after the second read.
- R3: While cmdReady is high, each cmdWrite appends cmdByte to the buffer, up to MAX_LEN bytes. Writes beyond MAX_LEN are dropped. A cmdGo with an empty buffer is ignored. A cmdWrite in the same cycle as an accepted cmdGo is dropped.
- R4: After an accepted cmdGo, the loaded bytes appear on rxData in load order, behind any fillers still pending, and rxEmpty is low in the next cycle.
- R5: Each rxRead while rxEmpty is low advances to the next byte. Reads on consecutive cycles are each honoured. A read while rxEmpty is high has no effect.
- R6: rxEmpty rises only in the cycle after a read that took the last available byte. While rxEmpty is low and no read occurs, rxEmpty stays low and rxData holds its value.
- R7: Echo bytes (txWrite) after launch are compared in order with the sent command. done is high in the cycle after the last byte matches, and mismatch is high in the cycle after the first byte that differs. Both clear on the next accepted cmdGo. Echo bytes while no command is pending have no effect.
- R8: cmdReady is low from the cycle after an accepted cmdGo until the echo check has finished and every byte has been read. cmdWrite and cmdGo have no effect while cmdReady is low.
- R9: txFull is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWrite | input | 1 | Append cmdByte to the command buffer |
| cmdByte | input | DATA_W | Command byte to load |
| cmdGo | input | 1 | Launch the loaded command |
| cmdReady | output | 1 | Buffer may be loaded and launched |
| rxData | output | DATA_W | Byte offered to the controller |
| rxEmpty | output | 1 | No byte offered |
| rxRead | input | 1 | Controller read strobe |
| txData | input | DATA_W | Echo byte from the controller |
| txWrite | input | 1 | Echo byte strobe |
| txFull | output | 1 | Echo channel full (always low) |
| done | output | 1 | Echo matched the command |
| mismatch | output | 1 | Echo differed from the command |

## Verification
A table of commands is run through the block. The entries differ in length (a single byte and several bytes) and in echo outcome: a clean echo, a wrong byte in the middle, and a wrong first byte. This separates completion that depends on length from stopping at the first difference. The offered bytes are read back as a continuous burst, so read pointers that skip or repeat a byte are caught. Directed cases cover the following:
- filler reads with and without a command already queued behind them;
- loading beyond capacity;
- a write in the same cycle as launch;
- writes while the block is busy;
- echoes while idle;
- an idle stretch in which the empty flag must not rise by itself.

// File: rtl/cmdInjectorPkg.sv
package cmdInjectorPkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic memWrite;   // store the incoming command byte
    logic showFill;   // present the filler byte instead of the buffer
  } ctrlStrobes_t;
endpackage

// File: rtl/cmdInjectorData.sv
module cmdInjectorData #(
  parameter int DATA_W    = 8,
  parameter int MAX_LEN   = 16,
  parameter logic [DATA_W-1:0] FILL_BYTE = 8'h20,
  localparam int ADDR_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic                        clk,
  input  cmdInjectorPkg::ctrlStrobes_t strobes,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [ADDR_W-1:0]           echoAddr,
  input  logic [DATA_W-1:0]           echoData,
  output logic [DATA_W-1:0]           rxData,
  output logic                        echoMatch
);
  logic [DATA_W-1:0] cmdMem [MAX_LEN];

  always_ff @(posedge clk) begin
    if (strobes.memWrite) cmdMem[wrAddr] <= wrData;
  end

  always_comb begin
    rxData    = strobes.showFill ? FILL_BYTE : cmdMem[rdAddr];
    echoMatch = (cmdMem[echoAddr] == echoData);
  end
endmodule

// File: rtl/cmdInjectorCtrl.sv
module cmdInjectorCtrl #(
  parameter int MAX_LEN    = 16,
  parameter int FILL_COUNT = 2,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int ADDR_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int FILL_W    = $clog2(FILL_COUNT + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdWrite,
  input  logic                         cmdGo,
  input  logic                         rxRead,
  input  logic                         txWrite,
  input  logic                         echoMatch,
  output cmdInjectorPkg::ctrlStrobes_t strobes,
  output logic [ADDR_W-1:0]            wrAddr,
  output logic [ADDR_W-1:0]            rdAddr,
  output logic [ADDR_W-1:0]            echoAddr,
  output logic                         rxEmpty,
  output logic                         cmdReady,
  output logic                         done,
  output logic                         mismatch
);
  localparam logic [LEN_W-1:0]  CAP       = LEN_W'(MAX_LEN);
  localparam logic [FILL_W-1:0] FILL_INIT = FILL_W'(FILL_COUNT);

  logic [LEN_W-1:0]  wrCount, sendLen, rdPtr, echoPtr;
  logic [FILL_W-1:0] fillLeft;
  logic              armed;
  logic              fillPending, sending, avail, readOk, goOk, writeOk, echoOk;

  always_comb begin
    fillPending = (fillLeft != '0);
    sending     = (rdPtr != sendLen);
    avail       = fillPending || sending;
    cmdReady    = !armed && !sending;
    readOk      = rxRead && avail;
    goOk        = cmdGo && cmdReady && (wrCount != '0);
    writeOk     = cmdWrite && cmdReady && !goOk && (wrCount < CAP);
    echoOk      = txWrite && armed;
    rxEmpty     = !avail;
    strobes.memWrite = writeOk;
    strobes.showFill = fillPending;
    wrAddr   = ADDR_W'(wrCount);
    rdAddr   = ADDR_W'(rdPtr);
    echoAddr = ADDR_W'(echoPtr);
  end

  // Read side: fillers first, then the launched command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillLeft <= FILL_INIT;
      rdPtr    <= '0;
      sendLen  <= '0;
    end else begin
      if (goOk) begin
        sendLen <= wrCount;
        rdPtr   <= '0;
      end else if (readOk && !fillPending) begin
        rdPtr <= rdPtr + LEN_W'(1);
      end
      if (readOk && fillPending) fillLeft <= fillLeft - FILL_W'(1);
    end
  end

  // Load side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCount <= '0;
    end else if (goOk) begin
      wrCount <= '0;
    end else if (writeOk) begin
      wrCount <= wrCount + LEN_W'(1);
    end
  end

  // Echo comparison
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      echoPtr  <= '0;
      done     <= 1'b0;
      mismatch <= 1'b0;
    end else if (goOk) begin
      armed    <= 1'b1;
      echoPtr  <= '0;
      done     <= 1'b0;
      mismatch <= 1'b0;
    end else if (echoOk) begin
      if (!echoMatch) begin
        mismatch <= 1'b1;
        armed    <= 1'b0;
      end else if (echoPtr == sendLen - LEN_W'(1)) begin
        done  <= 1'b1;
        armed <= 1'b0;
      end else begin
        echoPtr <= echoPtr + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/cmdInjector.sv
module cmdInjector #(
  parameter int DATA_W     = 8,
  parameter int MAX_LEN    = 16,
  parameter int FILL_COUNT = 2,
  parameter logic [DATA_W-1:0] FILL_BYTE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [DATA_W-1:0] cmdByte,
  input  logic              cmdGo,
  output logic              cmdReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxEmpty,
  input  logic              rxRead,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic              txFull,
  output logic              done,
  output logic              mismatch
);
  localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  cmdInjectorPkg::ctrlStrobes_t strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr, echoAddr;
  logic              echoMatch;

  // Every echo byte is consumed on arrival, so the echo channel never fills
  assign txFull = 1'b0;

  cmdInjectorCtrl #(.MAX_LEN(MAX_LEN), .FILL_COUNT(FILL_COUNT)) ctrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdGo(cmdGo),
    .rxRead(rxRead), .txWrite(txWrite), .echoMatch(echoMatch),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr), .echoAddr(echoAddr),
    .rxEmpty(rxEmpty), .cmdReady(cmdReady), .done(done), .mismatch(mismatch)
  );

  cmdInjectorData #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .FILL_BYTE(FILL_BYTE)) data (
    .clk(clk), .strobes(strobes), .wrAddr(wrAddr), .wrData(cmdByte),
    .rdAddr(rdAddr), .echoAddr(echoAddr), .echoData(txData),
    .rxData(rxData), .echoMatch(echoMatch)
  );
endmodule

// File: rtl/cmdInjectorChecker.sv
module cmdInjectorChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrite,
  input logic [DATA_W-1:0] cmdByte,
  input logic              cmdGo,
  input logic              cmdReady,
  input logic [DATA_W-1:0] rxData,
  input logic              rxEmpty,
  input logic              rxRead,
  input logic [DATA_W-1:0] txData,
  input logic              txWrite,
  input logic              txFull,
  input logic              done,
  input logic              mismatch
);
  assert_empty_rise_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEmpty) |-> $past(rxRead));

  assert_hold_without_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEmpty && !rxRead) |=> (!rxEmpty && $stable(rxData)));

  assert_done_after_echo_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(txWrite));

  assert_mismatch_after_echo_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mismatch) |-> $past(txWrite));

  assert_outcome_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && mismatch));

  assert_busy_after_go_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdReady) |-> $past(cmdGo));

  assert_tx_never_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |=> !txFull);
endmodule

bind cmdInjector cmdInjectorChecker #(.DATA_W(DATA_W)) chk (.*);

// File: tb/cmdInjector_test.sv
module cmdInjector_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrite = 1'b0, cmdGo = 1'b0, rxRead = 1'b0, txWrite = 1'b0;
  logic [7:0] cmdByte = 8'h00, txData = 8'h00;
  logic cmdReady, rxEmpty, txFull, done, mismatch;
  logic [7:0] rxData;
  int errors = 0, checks = 0;
  bit finished = 0;

  localparam int NV = 4;
  localparam logic [7:0] VEC_BYTES [NV][5] = '{
    '{8'h4E, 8'h20, 8'h43, 8'h31, 8'h00},
    '{8'h51, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h52, 8'h20, 8'h30, 8'h41, 8'h00},
    '{8'h53, 8'h20, 8'h31, 8'h32, 8'h46}};
  localparam int VEC_LEN [NV] = '{4, 1, 4, 5};
  localparam int VEC_BAD [NV] = '{-1, -1, 2, 0};

  cmdInjector uut (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdByte(cmdByte), .cmdGo(cmdGo),
    .cmdReady(cmdReady), .rxData(rxData), .rxEmpty(rxEmpty), .rxRead(rxRead),
    .txData(txData), .txWrite(txWrite), .txFull(txFull), .done(done), .mismatch(mismatch)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadByte(logic [7:0] b);
    cmdWrite = 1'b1; cmdByte = b; tick(); cmdWrite = 1'b0;
  endtask

  task automatic launch();
    cmdGo = 1'b1; tick(); cmdGo = 1'b0;
  endtask

  task automatic readOne(logic [7:0] exp, string tag);
    checkEq({tag, " rxEmpty"}, rxEmpty, 0);
    checkEq({tag, " rxData"}, rxData, exp);
    rxRead = 1'b1; tick(); rxRead = 1'b0;
  endtask

  task automatic echoOne(logic [7:0] b);
    txWrite = 1'b1; txData = b; tick(); txWrite = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; tick(); tick(); rstN = 1'b1; tick();
  endtask

  initial begin
    doReset();
    // R1 reset state
    checkEq("R1 rxEmpty", rxEmpty, 0);
    checkEq("R1 rxData", rxData, 8'h20);
    checkEq("R1 cmdReady", cmdReady, 1);
    checkEq("R1 done", done, 0);
    checkEq("R1 mismatch", mismatch, 0);
    checkEq("R9 txFull", txFull, 0);
    // R2 filler reads, burst of two
    checkEq("R2 filler0", rxData, 8'h20);
    rxRead = 1'b1; tick();
    checkEq("R2 filler1 present", rxEmpty, 0);
    checkEq("R2 filler1", rxData, 8'h20);
    tick(); rxRead = 1'b0;
    checkEq("R2 empty after fillers", rxEmpty, 1);
    // R5 read while empty has no effect
    rxRead = 1'b1; tick(); rxRead = 1'b0;
    checkEq("R5 empty read keeps empty", rxEmpty, 1);
    checkEq("R5 empty read ready", cmdReady, 1);
    // R3 go with nothing loaded is ignored
    launch();
    checkEq("R3 empty go ignored ready", cmdReady, 1);
    checkEq("R3 empty go ignored rxEmpty", rxEmpty, 1);
    // R7 echo while idle ignored
    echoOne(8'h4E);
    checkEq("R7 idle echo done", done, 0);
    checkEq("R7 idle echo mismatch", mismatch, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < VEC_LEN[v]; i++) loadByte(VEC_BYTES[v][i]);
      launch();
      checkEq("R8 busy after go", cmdReady, 0);
      checkEq("R4 rxEmpty falls after go", rxEmpty, 0);
      checkEq("R7 done cleared by go", done, 0);
      checkEq("R7 mismatch cleared by go", mismatch, 0);
      rxRead = 1'b1;
      for (int i = 0; i < VEC_LEN[v]; i++) begin
        checkEq($sformatf("R4 R5 vec%0d byte%0d", v, i), rxData, VEC_BYTES[v][i]);
        tick();
      end
      rxRead = 1'b0;
      checkEq("R6 empty after last read", rxEmpty, 1);
      checkEq("R8 busy until echo", cmdReady, 0);
      for (int i = 0; i < VEC_LEN[v]; i++) begin
        echoOne((i == VEC_BAD[v]) ? (VEC_BYTES[v][i] ^ 8'h01) : VEC_BYTES[v][i]);
        checkEq("R9 txFull", txFull, 0);
        if (i == VEC_BAD[v]) break;
        if (i < VEC_LEN[v] - 1) checkEq("R7 no early done", done, 0);
      end
      checkEq($sformatf("R7 vec%0d done", v), done, (VEC_BAD[v] < 0) ? 1 : 0);
      checkEq($sformatf("R7 vec%0d mismatch", v), mismatch, (VEC_BAD[v] < 0) ? 0 : 1);
      checkEq("R8 ready after finish", cmdReady, 1);
    end

    // R3 overflow: extra writes dropped
    for (int i = 0; i < 18; i++) loadByte(8'(i + 1));
    launch();
    rxRead = 1'b1;
    for (int i = 0; i < 16; i++) begin
      checkEq($sformatf("R3 overflow byte%0d", i), rxData, i + 1);
      tick();
    end
    rxRead = 1'b0;
    checkEq("R3 overflow length", rxEmpty, 1);
    for (int i = 0; i < 16; i++) echoOne(8'(i + 1));
    checkEq("R3 overflow echo done", done, 1);

    // R3 write in same cycle as go is dropped; R8 writes while busy dropped
    loadByte(8'h41);
    cmdWrite = 1'b1; cmdByte = 8'h42; cmdGo = 1'b1; tick();
    cmdWrite = 1'b0; cmdGo = 1'b0;
    checkEq("R8 busy", cmdReady, 0);
    loadByte(8'h5A);
    launch();
    // R6 no spontaneous rise of empty
    for (int i = 0; i < 5; i++) tick();
    checkEq("R6 empty stays low idle", rxEmpty, 0);
    readOne(8'h41, "R3 go-write single byte");
    checkEq("R3 go-write length 1", rxEmpty, 1);
    echoOne(8'h41);
    checkEq("R8 busy write ignored done", done, 1);

    // R2 command queued behind fillers
    doReset();
    loadByte(8'h58);
    launch();
    readOne(8'h20, "R2 queued filler0");
    readOne(8'h20, "R2 queued filler1");
    readOne(8'h58, "R4 byte after fillers");
    checkEq("R2 empty after queued cmd", rxEmpty, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule